// File: doc/BRIEF.md
# Coil Relay Health Monitor

This block watches a 32-bit readback word gathered from three actuator driver chassis. Twelve of its bits report whether a thermal overload relay on each driver channel is closed (healthy = 1). The block drives two separate paths from that word.

The monitoring path adds a programmable test word to a copy of the readback, modulo 2^32. It then ANDs the twelve relay bits of that sum and requires the result to stay true for a long, parameterised hold time (sixty seconds of clock cycles by default) before it raises a qualified all-healthy flag. The forwarded path feeds downstream watchdogs. When the bypass control is set, it clears the relay region of the word and sets the twelve relay positions to 1. The switch readbacks in the top byte always pass through unchanged. Per-stage healthy flags are decoded from the forwarded word, so with bypass on they report healthy.

All outputs are registered and follow the inputs with one clock of latency.

Top module: `relay_health_monitor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `fwd_word`, `stage1_ok`, `stage2_ok` and `all_ok` are 0.
- R2: Bits 31:24 of `fwd_word` equal bits 31:24 of `raw_word` from the previous cycle, whatever the bypass state.
- R3: With `bypass_en` high, bits 23:0 of `fwd_word` in the next cycle are 0x0F0F0F. That is, bits 0-3, 8-11 and 16-19 are 1, and bits 4-7, 12-15 and 20-23 are 0.
- R4: With `bypass_en` low, `fwd_word` in the next cycle equals `raw_word`.
- R5: The monitored word is `raw_word + test_word` modulo 2^32, and any carry out of bit 31 is dropped.
- R6: Relay bits are grouped per corner at offsets 0, 8 and 16. Within a group, offset +0 is stage-1 horizontal, +1 is stage-2 horizontal, +2 is stage-1 vertical and +3 is stage-2 vertical. `all_ok` rises at the clock edge where the AND of all twelve monitored relay bits has been sampled true on HOLD_CYCLES consecutive edges, and it stays high while that AND stays true.
- R7: The edge that samples any monitored relay bit at 0 clears `all_ok` and restarts the hold count.
- R8: `stage1_ok` and `stage2_ok` are the registered ANDs of the six stage-1 and the six stage-2 relay bits of the forwarded word.
- R9: With `bypass_en` high, both stage flags are 1 in the next cycle.
- R10: `test_word` has no effect on `fwd_word`, `stage1_ok` or `stage2_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_word | input | 32 | Readback word from the driver chassis |
| test_word | input | 32 | Value added to the monitoring copy |
| bypass_en | input | 1 | Force relay bits healthy in the forwarded word |
| fwd_word | output | 32 | Registered word for downstream watchdogs |
| stage1_ok | output | 1 | All six stage-1 relays healthy in forwarded word |
| stage2_ok | output | 1 | All six stage-2 relays healthy in forwarded word |
| all_ok | output | 1 | Qualified all-healthy flag from monitoring path |

## Verification
The hardest case to reach from the ports is the exact edge where `all_ok` rises. Random readbacks almost never keep all twelve relay bits high for a whole hold window. The bench therefore shortens HOLD_CYCLES and steers the random stimulus toward healthy relay fields with an occasional drop. It also runs directed windows that stop one cycle short of the hold time and one cycle past it. Directed test-word sums that carry out of bit 31, or that repair a broken relay bit, reach the monitoring-only behaviour that the forwarded path never shows.

// File: rtl/relay_mon_pkg.sv
package relay_mon_pkg;

   // Position of each actuator inside a four-bit corner group
   localparam int unsigned GRP_BITS   = 4;
   localparam int unsigned POS_S1_HOR = 0;
   localparam int unsigned POS_S2_HOR = 1;
   localparam int unsigned POS_S1_VER = 2;
   localparam int unsigned POS_S2_VER = 3;

   // Word with one group of GRP_BITS ones per corner, at STRIDE spacing
   function automatic logic [63:0] relay_field_mask(int unsigned corners, int unsigned stride);
      logic [63:0] m;
      m = '0;
      for (int c = 0; c < int'(corners); c++) begin
         for (int b = 0; b < int'(GRP_BITS); b++) begin
            m[c*int'(stride) + b] = 1'b1;
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/relay_bit_decode.sv
module relay_bit_decode
   import relay_mon_pkg::*;
#(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned CORNERS = 3,
   parameter int unsigned STRIDE  = 8
) (
   input  logic [WORD_W-1:0]    word_i,
   output logic [2*CORNERS-1:0] stage1_bits_o,
   output logic [2*CORNERS-1:0] stage2_bits_o
);
   initial begin
      if (CORNERS * STRIDE > WORD_W) $error("relay groups exceed word width");
      if (STRIDE < GRP_BITS) $error("corner stride smaller than group");
   end

   for (genvar c = 0; c < CORNERS; c++) begin : g_corner
      localparam int unsigned BASE = c * STRIDE;
      assign stage1_bits_o[2*c]   = word_i[BASE + POS_S1_HOR];
      assign stage1_bits_o[2*c+1] = word_i[BASE + POS_S1_VER];
      assign stage2_bits_o[2*c]   = word_i[BASE + POS_S2_HOR];
      assign stage2_bits_o[2*c+1] = word_i[BASE + POS_S2_VER];
   end
endmodule

// File: rtl/relay_word_gate.sv
module relay_word_gate #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned PASS_LSB = 24,
   parameter logic [WORD_W-1:0] FORCE_ONES = '0
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic              bypass_i,
   output logic [WORD_W-1:0] word_o
);
   localparam logic [WORD_W-1:0] KEEP_MASK = ~((WORD_W'(1) << PASS_LSB) - WORD_W'(1));

   initial begin
      if (PASS_LSB >= WORD_W) $error("pass-through field empty");
      if ((FORCE_ONES & KEEP_MASK) != '0) $error("forced bits overlap pass-through field");
   end

   always_comb begin
      if (bypass_i) word_o = (word_i & KEEP_MASK) + FORCE_ONES;
      else          word_o = word_i;
   end
endmodule

// File: rtl/relay_persist_qual.sv
module relay_persist_qual #(
   parameter longint unsigned HOLD_CYCLES = 64'd6_000_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond_i,
   output logic qual_o
);
   localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYCLES);

   initial begin
      if (HOLD_CYCLES < 1) $error("hold time must be at least one cycle");
   end

   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= '0;
         qual_o <= 1'b0;
      end else if (!cond_i) begin
         run_q  <= '0;
         qual_o <= 1'b0;
      end else if (run_q != LIMIT) begin
         run_q  <= run_q + 1'b1;
         qual_o <= (run_q == LIMIT - 1'b1);
      end else begin
         qual_o <= 1'b1;
      end
   end
endmodule

// File: rtl/relay_health_monitor.sv
module relay_health_monitor
   import relay_mon_pkg::*;
#(
   parameter int unsigned     WORD_W      = 32,
   parameter int unsigned     CORNERS     = 3,
   parameter int unsigned     STRIDE      = 8,
   parameter int unsigned     PASS_LSB    = 24,
   parameter longint unsigned HOLD_CYCLES = 64'd6_000_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] raw_word,
   input  logic [WORD_W-1:0] test_word,
   input  logic              bypass_en,
   output logic [WORD_W-1:0] fwd_word,
   output logic              stage1_ok,
   output logic              stage2_ok,
   output logic              all_ok
);
   localparam logic [WORD_W-1:0] RELAY_MASK = WORD_W'(relay_field_mask(CORNERS, STRIDE));
   localparam int unsigned       HALF       = 2 * CORNERS;

   initial begin
      if (WORD_W > 64) $error("word width above 64 unsupported");
      if (CORNERS * STRIDE > PASS_LSB) $error("relay groups overlap pass-through field");
   end

   // Monitoring copy: modulo sum, carry dropped by width
   logic [WORD_W-1:0] mon_word;
   logic [HALF-1:0]   mon_s1, mon_s2;
   logic              mon_all;

   assign mon_word = raw_word + test_word;

   relay_bit_decode #(.WORD_W(WORD_W), .CORNERS(CORNERS), .STRIDE(STRIDE)) u_mon_dec (
      .word_i        (mon_word),
      .stage1_bits_o (mon_s1),
      .stage2_bits_o (mon_s2)
   );

   assign mon_all = (&mon_s1) & (&mon_s2);

   relay_persist_qual #(.HOLD_CYCLES(HOLD_CYCLES)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_i (mon_all),
      .qual_o (all_ok)
   );

   // Forwarded path
   logic [WORD_W-1:0] gated_word;
   logic [HALF-1:0]   fw_s1, fw_s2;

   relay_word_gate #(.WORD_W(WORD_W), .PASS_LSB(PASS_LSB), .FORCE_ONES(RELAY_MASK)) u_gate (
      .word_i   (raw_word),
      .bypass_i (bypass_en),
      .word_o   (gated_word)
   );

   relay_bit_decode #(.WORD_W(WORD_W), .CORNERS(CORNERS), .STRIDE(STRIDE)) u_fwd_dec (
      .word_i        (gated_word),
      .stage1_bits_o (fw_s1),
      .stage2_bits_o (fw_s2)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_word  <= '0;
         stage1_ok <= 1'b0;
         stage2_ok <= 1'b0;
      end else begin
         fwd_word  <= gated_word;
         stage1_ok <= &fw_s1;
         stage2_ok <= &fw_s2;
      end
   end
endmodule

// File: rtl/relay_health_monitor_chk.sv
module relay_health_monitor_chk #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned PASS_LSB = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] raw_word,
   input logic [WORD_W-1:0] test_word,
   input logic              bypass_en,
   input logic [WORD_W-1:0] fwd_word,
   input logic              stage1_ok,
   input logic              stage2_ok,
   input logic              all_ok
);
   logic [WORD_W-1:0] sum_w;
   logic              sum_all;
   assign sum_w   = raw_word + test_word;
   assign sum_all = (sum_w[3:0] == 4'hF) && (sum_w[11:8] == 4'hF) && (sum_w[19:16] == 4'hF);

   a_r2_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> fwd_word[WORD_W-1:PASS_LSB] == $past(raw_word[WORD_W-1:PASS_LSB]));

   a_r3_bypass_forced: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_en |=> fwd_word[23:0] == 24'h0F0F0F);

   a_r4_transparent: assert property (@(posedge clk) disable iff (!rst_n)
      !bypass_en |=> fwd_word == $past(raw_word));

   a_r7_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !sum_all |=> !all_ok);

   a_r6_rise_needs_health: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(all_ok) |-> $past(sum_all));

   a_r9_bypass_stages: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_en |=> stage1_ok && stage2_ok);

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> fwd_word == '0 && !all_ok && !stage1_ok && !stage2_ok);
endmodule

bind relay_health_monitor relay_health_monitor_chk #(.WORD_W(WORD_W), .PASS_LSB(PASS_LSB)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .raw_word  (raw_word),
   .test_word (test_word),
   .bypass_en (bypass_en),
   .fwd_word  (fwd_word),
   .stage1_ok (stage1_ok),
   .stage2_ok (stage2_ok),
   .all_ok    (all_ok)
);

// File: tb/relay_health_monitor_test.sv
module relay_health_monitor_test;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] raw_word = '0, test_word = '0;
   logic        bypass_en = 1'b0;
   logic [31:0] fwd_word;
   logic        stage1_ok, stage2_ok, all_ok;

   int vectors = 0, fails = 0, run = 0;
   logic [31:0] e_fwd;
   logic e_s1, e_s2, e_all;

   always #(CLK_PERIOD/2) clk = ~clk;

   relay_health_monitor #(.HOLD_CYCLES(HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .raw_word(raw_word), .test_word(test_word),
      .bypass_en(bypass_en), .fwd_word(fwd_word), .stage1_ok(stage1_ok),
      .stage2_ok(stage2_ok), .all_ok(all_ok)
   );

   function automatic logic [31:0] model_fwd(logic [31:0] w, logic byp);
      return byp ? ((w & 32'hFF00_0000) + 32'h000F_0F0F) : w;
   endfunction
   function automatic logic st1(logic [31:0] w);
      return w[0] & w[2] & w[8] & w[10] & w[16] & w[18];
   endfunction
   function automatic logic st2(logic [31:0] w);
      return w[1] & w[3] & w[9] & w[11] & w[17] & w[19];
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One cycle: drive at negedge, compare just after the capturing edge
   task automatic step(logic [31:0] w, logic [31:0] t, logic byp, string req);
      logic [31:0] sum;
      @(negedge clk);
      raw_word = w; test_word = t; bypass_en = byp;
      sum = w + t;
      e_fwd = model_fwd(w, byp);
      e_s1 = st1(e_fwd);
      e_s2 = st2(e_fwd);
      if (st1(sum) & st2(sum)) run = (run < HOLD) ? run + 1 : run; else run = 0;
      e_all = (run >= HOLD);
      @(posedge clk); #1;
      check({req, " R2/R3/R4/R10 fwd"}, fwd_word, e_fwd);
      check({req, " R8/R9 stage1"}, {31'd0, stage1_ok}, {31'd0, e_s1});
      check({req, " R8/R9 stage2"}, {31'd0, stage2_ok}, {31'd0, e_s2});
      check({req, " R5/R6/R7 all_ok"}, {31'd0, all_ok}, {31'd0, e_all});
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      raw_word = 32'hFFFF_FFFF; bypass_en = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset fwd", fwd_word, 32'h0);
      check("R1 reset flags", {29'd0, stage1_ok, stage2_ok, all_ok}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      // R4 transparent, R2 upper byte
      step(32'hA5C3_1234, 32'h0, 1'b0, "R4 plain");
      // R3 bypass with noisy low bits
      step(32'h5AF0_F0F0, 32'h0, 1'b1, "R3 bypass");
      // R8 single stage broken: clear stage-2 vertical of corner 3 (bit 19)
      step(32'h0007_0F0F, 32'h0, 1'b0, "R8 s2 break");
      step(32'h000F_0F0B, 32'h0, 1'b0, "R8 s1 break");
      // R6 hold window: healthy HOLD-1 cycles -> low, HOLD-th -> high
      for (int i = 0; i < HOLD + 2; i++) step(32'h000F_0F0F, 32'h0, 1'b0, "R6 hold");
      // R7 single bit drop
      step(32'h000F_0F0E, 32'h0, 1'b0, "R7 drop");
      // R5 test word repairs bit 0 (R10: fwd unaffected)
      for (int i = 0; i < HOLD; i++) step(32'h000F_0F0E, 32'h1, 1'b0, "R5 repair");
      // R5 carry out of bit 31 dropped: sum wraps to zero
      step(32'hFFFF_FFFF, 32'h1, 1'b1, "R5 wrap");
      // R10 test word on forwarded path with bypass high
      step(32'h1234_5678, 32'hFFFF_FFFF, 1'b1, "R10 test ignored");

      // Random mix biased toward healthy relay fields
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] w, t;
         w = $urandom();
         if ($urandom_range(0, 15) != 0) w = w | 32'h000F_0F0F;
         t = ($urandom_range(0, 7) == 0) ? $urandom() : 32'h0;
         step(w, t, ($urandom_range(0, 3) == 0), "rand");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule